// File: doc/BRIEF.md
# Byte-wide Stack Transfer Sequencer

This block moves 16-bit register-pair values between a processor core and a byte-wide stack held in an ordinary synchronous memory. It owns the 16-bit stack pointer. A single command port starts one of four operations: push a pair, pop a pair, swap a pair with the two bytes on top of the stack, or load the pointer from a pair. The block then performs the byte transfers itself, one memory access per clock.

The memory port is a plain single-port interface. An access is requested with `mem_en`, and `mem_we` selects a write. Read data appears on `mem_rdata` in the cycle after the read request. The stack grows downward. The high byte of a pair always sits at the higher address. When the accumulator and flags are pushed together, the caller places the accumulator in bits 15:8 and the flags in bits 7:0.

While an operation runs, `busy` is high and further commands are ignored. A one-cycle `done` pulse marks completion. For pop and exchange, `rsp_data` carries the value taken from the stack in the `done` cycle.

Top module: `stack_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_en` are low and `sp_out` equals the parameter `SP_INIT` (default 0000h). While the block is idle, `mem_en` stays low.
- R2: A push (`cmd_op` = 2'b00) writes, in order:
  - `cmd_data[15:8]` at SP-1 in the first cycle after acceptance;
  - `cmd_data[7:0]` at SP-2 in the second cycle.

  The pointer ends at SP-2. This also holds for an accumulator/flags pair, with the accumulator in the high byte.
- R3: A pop (`cmd_op` = 2'b01) performs two reads:
  - the low byte from SP in the first cycle after acceptance;
  - the high byte from SP+1 in the second cycle.

  The pointer ends at SP+2. `rsp_data` = {byte at SP+1, byte at SP} in the `done` cycle, which is the fourth cycle after acceptance.
- R4: An exchange (`cmd_op` = 2'b10) uses four consecutive cycles:
  - a read of SP, then a read of SP+1;
  - a write of `cmd_data[7:0]` to SP, then a write of `cmd_data[15:8]` to SP+1.

  `sp_out` does not change. `rsp_data` holds the old {byte at SP+1, byte at SP} in the fifth cycle, together with `done`.
- R5: A pointer load (`cmd_op` = 2'b11) makes no memory access. `sp_out` takes `cmd_data` in the second cycle after acceptance, together with `done`.
- R6: All pointer and address arithmetic wraps modulo 2^16. A push at SP = 0000h writes FFFFh and then FFFEh, and an exchange at FFFFh uses FFFFh and 0000h.
- R7: `busy` is high from the cycle after acceptance up to the last cycle of the operation. `done` is a single-cycle pulse while `busy` is low. The pointer moves by at most one step per cycle.
- R8: A command presented while `busy` is high is ignored: no extra memory access, pointer change or `done` pulse results from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 00 push, 01 pop, 10 exchange, 11 load pointer |
| cmd_data | input | 16 | Pair value; bits 15:8 high byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Value taken by pop or exchange |
| sp_out | output | 16 | Current stack pointer |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write select for the access |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read |

## Verification
Counting from the clock edge that accepts a command, each result has a fixed due cycle:
- a push's two writes fall in cycles 1 and 2, with `done` in cycle 3;
- a pop's reads fall in cycles 1 and 2, with its result and `done` in cycle 4;
- an exchange's reads fall in cycles 1–2 and its writes in cycles 3–4, with its result in cycle 5;
- a pointer load finishes in cycle 2.

When the bench accepts a command, its reference model places one expected entry per cycle in a queue. The checker takes one entry on every falling edge and compares it against the bus, pointer, busy, done and result outputs. An empty queue means the block should be idle. Acceptance is decided from the model's own busy state, so a command given while busy produces no entries, and any reaction to it shows up as a mismatch.

// File: rtl/stack_xfer_pkg.sv
package stack_xfer_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_XCHG = 2'b10,
    OP_LDSP = 2'b11
  } sx_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_H,
    ST_PUSH_L,
    ST_POP_L,
    ST_POP_H,
    ST_POP_F,
    ST_XR_L,
    ST_XR_H,
    ST_XW_L,
    ST_XW_H,
    ST_LD
  } sx_state_e;
endpackage

// File: rtl/sx_pointer.sv
module sx_pointer #(
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_dn,
  input  logic          step_up,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] sp
);
  function automatic logic [AW-1:0] ptr_dn(input logic [AW-1:0] v);
    return v - 1'b1;
  endfunction

  function automatic logic [AW-1:0] ptr_up(input logic [AW-1:0] v);
    return v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       sp <= SP_INIT;
    else if (load)    sp <= load_val;
    else if (step_dn) sp <= ptr_dn(sp);
    else if (step_up) sp <= ptr_up(sp);
  end

  // R7: the controller never asks for two pointer updates in one cycle
  a_r7_single_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_dn, step_up, load}));
endmodule

// File: rtl/sx_control.sv
module sx_control
  import stack_xfer_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [2*BW-1:0] cmd_data,
  input  logic [BW-1:0]   mem_rdata,
  output sx_state_e       state,
  output logic [2*BW-1:0] data_q,
  output logic            step_dn,
  output logic            step_up,
  output logic            load,
  output logic            done,
  output logic [2*BW-1:0] rsp_data
);
  logic [BW-1:0] lo_q, hi_q;
  logic          accept;
  sx_op_e        op_in;

  assign op_in  = sx_op_e'(cmd_op);
  assign accept = (state == ST_IDLE) && cmd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      data_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      rsp_data <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          data_q <= cmd_data;
          unique case (op_in)
            OP_PUSH: state <= ST_PUSH_H;
            OP_POP:  state <= ST_POP_L;
            OP_XCHG: state <= ST_XR_L;
            OP_LDSP: state <= ST_LD;
          endcase
        end
        ST_PUSH_H: state <= ST_PUSH_L;
        ST_PUSH_L: begin state <= ST_IDLE; done <= 1'b1; end
        ST_POP_L:  state <= ST_POP_H;
        ST_POP_H:  begin state <= ST_POP_F; lo_q <= mem_rdata; end
        ST_POP_F: begin
          state    <= ST_IDLE;
          rsp_data <= {mem_rdata, lo_q};
          done     <= 1'b1;
        end
        ST_XR_L:   state <= ST_XR_H;
        ST_XR_H:   begin state <= ST_XW_L; lo_q <= mem_rdata; end
        ST_XW_L:   begin state <= ST_XW_H; hi_q <= mem_rdata; end
        ST_XW_H: begin
          state    <= ST_IDLE;
          rsp_data <= {hi_q, lo_q};
          done     <= 1'b1;
        end
        ST_LD:     begin state <= ST_IDLE; done <= 1'b1; end
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    step_dn = (accept && op_in == OP_PUSH) || (state == ST_PUSH_H);
    step_up = (state == ST_POP_L) || (state == ST_POP_H);
    load    = (state == ST_LD);
  end

  // R8: every operation starts from idle, so a command seen while busy never restarts one
  a_r8_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH_H || state == ST_POP_L || state == ST_XR_L || state == ST_LD)
      |-> $past(state) == ST_IDLE);
endmodule

// File: rtl/sx_memport.sv
module sx_memport
  import stack_xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  sx_state_e       state,
  input  logic [AW-1:0]   sp,
  input  logic [2*BW-1:0] data_q,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [BW-1:0]   mem_wdata
);
  function automatic logic [AW-1:0] above(input logic [AW-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic [BW-1:0] hi_byte(input logic [2*BW-1:0] v);
    return v[2*BW-1:BW];
  endfunction

  function automatic logic [BW-1:0] lo_byte(input logic [2*BW-1:0] v);
    return v[BW-1:0];
  endfunction

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp;
    mem_wdata = '0;
    unique case (state)
      ST_PUSH_H: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = hi_byte(data_q); end
      ST_PUSH_L: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = lo_byte(data_q); end
      ST_POP_L, ST_POP_H, ST_XR_L: mem_en = 1'b1;
      ST_XR_H:   begin mem_en = 1'b1; mem_addr = above(sp); end
      ST_XW_L:   begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = lo_byte(data_q); end
      ST_XW_H: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = above(sp);
        mem_wdata = hi_byte(data_q);
      end
      default: mem_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq
  import stack_xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter logic [AW-1:0] SP_INIT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [2*BW-1:0] cmd_data,
  output logic            busy,
  output logic            done,
  output logic [2*BW-1:0] rsp_data,
  output logic [AW-1:0]   sp_out,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [BW-1:0]   mem_wdata,
  input  logic [BW-1:0]   mem_rdata
);
  localparam int PW = 2 * BW;

  sx_state_e     state;
  logic [PW-1:0] data_q;
  logic          step_dn, step_up, load;

  sx_control #(.BW(BW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .mem_rdata(mem_rdata), .state(state), .data_q(data_q),
    .step_dn(step_dn), .step_up(step_up), .load(load), .done(done),
    .rsp_data(rsp_data)
  );

  sx_pointer #(.AW(AW), .SP_INIT(SP_INIT)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step_dn(step_dn), .step_up(step_up),
    .load(load), .load_val(data_q[AW-1:0]), .sp(sp_out)
  );

  sx_memport #(.AW(AW), .BW(BW)) u_mem (
    .state(state), .sp(sp_out), .data_q(data_q), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign busy = (state != ST_IDLE);

  function automatic logic [AW-1:0] addr_dn(input logic [AW-1:0] v);
    return v - 1'b1;
  endfunction

  function automatic logic [AW-1:0] addr_up(input logic [AW-1:0] v);
    return v + 1'b1;
  endfunction

  // R1: no memory traffic while idle
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);
  // R7: done is a lone pulse outside busy
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2 and R6: second push byte goes one address below the first, modulo 2^16
  a_r2_push_low_below: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH_L) |-> mem_we && mem_addr == addr_dn($past(mem_addr)));
  // R3: second pop read is one address above the first
  a_r3_pop_high_above: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POP_H) |-> !mem_we && mem_addr == addr_up($past(mem_addr)));
  // R4: exchange keeps the pointer and writes back where it read
  a_r4_xchg_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XR_H || state == ST_XW_L || state == ST_XW_H) |-> $stable(sp_out));
  a_r4_write_where_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XW_L) |-> mem_we && mem_addr == $past(mem_addr, 2));
  // R5: pointer load makes no access
  a_r5_load_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LD) |-> !mem_en);
endmodule

// File: tb/tb_stack_xfer_seq.sv
module tb_stack_xfer_seq;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] cmd_data = '0;
  logic        busy, done, mem_en, mem_we;
  logic [15:0] rsp_data, sp_out, mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  bit checking = 1'b0;
  bit last_busy = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stack_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .busy(busy), .done(done), .rsp_data(rsp_data),
    .sp_out(sp_out), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory seen by the design, and a separate copy owned by the model
  logic [7:0] ram[int];
  logic [7:0] ref_mem[int];

  function automatic logic [7:0] seed(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ram_rd(input logic [15:0] a);
    if (ram.exists(int'(a))) return ram[int'(a)];
    return seed(a);
  endfunction

  function automatic logic [7:0] ref_rd(input logic [15:0] a);
    if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
    return seed(a);
  endfunction

  always @(posedge clk) begin
    if (mem_en && mem_we) ram[int'(mem_addr)] = mem_wdata;
    else if (mem_en) mem_rdata <= ram_rd(mem_addr);
  end

  typedef struct {
    bit          busy;
    bit          done;
    bit          en;
    bit          we;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [15:0] sp;
    bit          rchk;
    logic [15:0] rsp;
    string       tag;
  } exp_t;

  exp_t expq[$];
  logic [15:0] ref_sp = 16'h0000;

  function automatic exp_t mk(bit b, bit d, bit e, bit w, logic [15:0] a,
                              logic [7:0] wd, logic [15:0] s, bit rc,
                              logic [15:0] r, string t);
    exp_t x;
    x.busy = b; x.done = d; x.en = e; x.we = w; x.addr = a; x.wd = wd;
    x.sp = s; x.rchk = rc; x.rsp = r; x.tag = t;
    return x;
  endfunction

  task automatic check(input bit ok, input string t, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", t, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model queue
  always @(negedge clk) begin
    if (checking) begin
      exp_t e;
      if (expq.size() > 0) e = expq.pop_front();
      else e = mk(0, 0, 0, 0, '0, '0, ref_sp, 0, '0, "R1");
      last_busy = e.busy;
      check(busy == e.busy, e.tag, "busy", 16'(busy), 16'(e.busy));
      check(done == e.done, e.tag, "done", 16'(done), 16'(e.done));
      check(mem_en == e.en, e.tag, "mem_en", 16'(mem_en), 16'(e.en));
      check(sp_out == e.sp, e.tag, "sp_out", sp_out, e.sp);
      if (e.en) begin
        check(mem_we == e.we, e.tag, "mem_we", 16'(mem_we), 16'(e.we));
        check(mem_addr == e.addr, e.tag, "mem_addr", mem_addr, e.addr);
        if (e.we) check(mem_wdata == e.wd, e.tag, "mem_wdata", 16'(mem_wdata), 16'(e.wd));
      end
      if (e.rchk) check(rsp_data == e.rsp, e.tag, "rsp_data", rsp_data, e.rsp);
    end
  end

  task automatic model(input logic [1:0] op, input logic [15:0] d, input string t);
    logic [15:0] s;
    logic [15:0] s1;
    logic [15:0] s2;
    logic [15:0] old;
    s  = ref_sp;
    case (op)
      2'b00: begin
        s1 = s - 16'd1; s2 = s - 16'd2;
        expq.push_back(mk(1, 0, 1, 1, s1, d[15:8], s1, 0, '0, t));
        expq.push_back(mk(1, 0, 1, 1, s2, d[7:0], s2, 0, '0, t));
        expq.push_back(mk(0, 1, 0, 0, '0, '0, s2, 0, '0, t));
        ref_mem[int'(s1)] = d[15:8];
        ref_mem[int'(s2)] = d[7:0];
        ref_sp = s2;
      end
      2'b01: begin
        s1 = s + 16'd1; s2 = s + 16'd2;
        old = {ref_rd(s1), ref_rd(s)};
        expq.push_back(mk(1, 0, 1, 0, s, '0, s, 0, '0, t));
        expq.push_back(mk(1, 0, 1, 0, s1, '0, s1, 0, '0, t));
        expq.push_back(mk(1, 0, 0, 0, '0, '0, s2, 0, '0, t));
        expq.push_back(mk(0, 1, 0, 0, '0, '0, s2, 1, old, t));
        ref_sp = s2;
      end
      2'b10: begin
        s1 = s + 16'd1;
        old = {ref_rd(s1), ref_rd(s)};
        expq.push_back(mk(1, 0, 1, 0, s, '0, s, 0, '0, t));
        expq.push_back(mk(1, 0, 1, 0, s1, '0, s, 0, '0, t));
        expq.push_back(mk(1, 0, 1, 1, s, d[7:0], s, 0, '0, t));
        expq.push_back(mk(1, 0, 1, 1, s1, d[15:8], s, 0, '0, t));
        expq.push_back(mk(0, 1, 0, 0, '0, '0, s, 1, old, t));
        ref_mem[int'(s)]  = d[7:0];
        ref_mem[int'(s1)] = d[15:8];
      end
      default: begin
        expq.push_back(mk(1, 0, 0, 0, '0, '0, s, 0, '0, t));
        expq.push_back(mk(0, 1, 0, 0, '0, '0, d, 0, '0, t));
        ref_sp = d;
      end
    endcase
  endtask

  task automatic cmd(input logic [1:0] op, input logic [15:0] d, input string t);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = d;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    if (!last_busy) model(op, d, t);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    checking = 1'b1;
    idle(2);                              // R1 reset and idle state
    cmd(2'b11, 16'h2000, "R5");           // load pointer
    idle(3);
    cmd(2'b00, 16'hA1B2, "R2");           // push
    idle(4);
    cmd(2'b00, 16'h44D5, "R2");           // accumulator/flags pair
    idle(4);
    cmd(2'b10, 16'h1122, "R4");           // exchange with top
    idle(6);
    cmd(2'b01, 16'h0000, "R3");           // pop gets exchanged value
    idle(5);
    cmd(2'b01, 16'h0000, "R3");
    idle(5);
    cmd(2'b01, 16'h0000, "R3");           // pop of untouched memory
    idle(5);
    cmd(2'b11, 16'h0000, "R6");
    idle(3);
    cmd(2'b00, 16'hBEEF, "R6");           // push wraps to FFFF/FFFE
    idle(4);
    cmd(2'b01, 16'h0000, "R6");           // pop wraps back to 0000
    idle(5);
    cmd(2'b11, 16'hFFFF, "R6");
    idle(3);
    cmd(2'b10, 16'h7788, "R6");           // exchange across FFFF/0000
    idle(6);
    cmd(2'b00, 16'h5A5A, "R8");           // push, then commands while busy
    cmd(2'b01, 16'h0000, "R8");
    cmd(2'b11, 16'h1234, "R8");
    idle(4);
    cmd(2'b10, 16'h9999, "R8");
    cmd(2'b00, 16'hCCCC, "R8");
    idle(6);
    cmd(2'b00, 16'h0F0F, "R7");           // back-to-back on done cycles
    while (!last_busy) @(negedge clk);
    while (last_busy) @(negedge clk);
    cmd(2'b01, 16'h0000, "R7");
    idle(6);
    checking = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule